// File: doc/BRIEF.md
# Real-Time Trace Status and Data Port

This block produces a narrow trace stream for following a processor's execution path while the processor keeps running. It drives two 4-bit buses. The status bus carries the core's own per-cycle execution codes. The block also places byte-count markers on the status bus in cycles where the core reports nothing. The data bus carries captured 32-bit values as a nibble sequence. Each value sits behind its marker, so an external analyser can tie every value to the instruction that produced it.

There are three capture sources. Taken-branch target addresses are sized by a target-size field. Bus operands are filtered by direction through an operand field and sized by the transfer size. Explicit write-to-trace requests from the core are always captured. Captured values wait in a small buffer. The core is held only when every buffer entry is occupied. While nothing is being serialised, the data bus shows a breakpoint-trigger code.

Top module: `trace_port`

## Requirements
- R1: During reset `pst_out`, `ddata_out` and `core_stall` are all 0.
- R2: Any nonzero `core_pst` value appears on `pst_out` exactly one clock later. Core codes never use the pattern 10xx.
- R3: A `branch_req` captures `branch_addr` with a byte count set by `tgt_cfg`: 00 captures nothing, 01 captures 2 bytes, 10 captures 3 bytes and 11 captures 4 bytes.
- R4: An `opd_req` is captured when `opd_cfg[0]` is set for a write (`opd_wr`=1) or when `opd_cfg[1]` is set for a read. The byte count comes from `opd_size`: 00 gives 1 byte, 01 gives 2 bytes, and 10 or 11 give 4 bytes.
- R5: A `wdd_req` always captures `wdd_data`, with the byte count taken from `wdd_size` using the R4 mapping.
- R6: A marker is `{2'b10, bytes-1}`, so 1000, 1001, 1010 or 1011. It is issued for the oldest pending value only in a cycle where the serialiser is idle and `core_pst` is 0000. It appears on `pst_out` one clock later, in place of that 0000.
- R7: Starting in the cycle after the marker, `ddata_out` shows 2×bytes nibbles on consecutive clocks, least significant nibble first.
- R8: `core_stall` is high exactly when both buffer entries hold values that are not fully shown. Requests presented while `core_stall` is high are dropped.
- R9: When no value is being serialised, `ddata_out` shows `trig_code` one clock later. It therefore reads 0000 when there is no trigger.
- R10: When several captures qualify in one cycle, only one is taken. Priority is branch first, then operand, then write-to-trace; the others are dropped.
- R11: Values are shown in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_cfg | input | 2 | Branch target capture size |
| opd_cfg | input | 2 | Operand direction filter (bit0 writes, bit1 reads) |
| core_pst | input | 4 | Core execution status code for this cycle |
| branch_req | input | 1 | Taken branch with traceable target |
| branch_addr | input | 32 | Branch target address |
| opd_req | input | 1 | Operand bus transfer |
| opd_wr | input | 1 | Operand transfer is a write |
| opd_size | input | 2 | Operand transfer size |
| opd_data | input | 32 | Operand value |
| wdd_req | input | 1 | Explicit write-to-trace request |
| wdd_size | input | 2 | Size of explicit write-to-trace value |
| wdd_data | input | 32 | Explicit write-to-trace value |
| trig_code | input | 4 | Breakpoint trigger indication |
| pst_out | output | 4 | Trace status bus |
| ddata_out | output | 4 | Trace data bus |
| core_stall | output | 1 | Hold request to the core |

## Verification
The hardest state to reach is a full buffer. The serialiser drains an entry within about ten cycles once a marker slot exists, so two back-to-back captures normally never meet. The stimulus holds `core_pst` at a nonzero code, which denies the block any marker slot. It then issues two write-to-trace requests in a row, so the buffer fills and the stall rises. A third request is offered during the stall and must be dropped. After that the status code returns to 0000, and the bench checks that exactly the first two values drain, in order.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned TW  = 32;
  localparam int unsigned NIB = TW / 4;
  localparam int unsigned IW  = $clog2(NIB);

  // blen holds (byte count - 1)
  typedef struct packed {
    logic [1:0]    blen;
    logic [TW-1:0] val;
  } trace_item_t;

  function automatic logic [1:0] size_to_blen(input logic [1:0] sz);
    case (sz)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
(
  input  logic          accept_en,
  input  logic [1:0]    tgt_cfg,
  input  logic [1:0]    opd_cfg,
  input  logic          branch_req,
  input  logic [TW-1:0] branch_addr,
  input  logic          opd_req,
  input  logic          opd_wr,
  input  logic [1:0]    opd_size,
  input  logic [TW-1:0] opd_data,
  input  logic          wdd_req,
  input  logic [1:0]    wdd_size,
  input  logic [TW-1:0] wdd_data,
  output logic          push,
  output trace_item_t   item
);
  logic br_ok, op_ok;

  always_comb begin
    br_ok = branch_req && (tgt_cfg != 2'b00);
    op_ok = opd_req && (opd_wr ? opd_cfg[0] : opd_cfg[1]);
    push  = accept_en && (br_ok || op_ok || wdd_req);
    if (br_ok) begin
      item.blen = tgt_cfg;
      item.val  = branch_addr;
    end else if (op_ok) begin
      item.blen = size_to_blen(opd_size);
      item.val  = opd_data;
    end else begin
      item.blen = size_to_blen(wdd_size);
      item.val  = wdd_data;
    end
  end
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
  import trace_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  trace_item_t din,
  input  logic        pop,
  output logic        head_vld,
  output trace_item_t head,
  output logic        full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  trace_item_t   mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop = pop && (cnt_q != '0);
    wr_d   = push ? nxt(wr_q) : wr_q;
    rd_d   = do_pop ? nxt(rd_q) : rd_q;
    cnt_d  = cnt_q + CW'(push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign head_vld = (cnt_q != '0);
  assign head     = mem[rd_q];
  assign full     = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
  import trace_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  core_pst,
  input  logic [3:0]  trig_code,
  input  logic        head_vld,
  input  trace_item_t head,
  output logic        pop,
  output logic        busy,
  output logic [3:0]  pst_out,
  output logic [3:0]  ddata_out
);
  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d, last_idx;
  logic [3:0]    pst_q, pst_d, dd_q, dd_d;
  logic          start;
  logic [TW-1:0] shifted;

  always_comb begin
    start    = !busy_q && head_vld && (core_pst == 4'd0);
    last_idx = IW'({head.blen, 1'b1});
    shifted  = head.val >> {idx_q, 2'b00};
    pst_d    = start ? {2'b10, head.blen} : core_pst;
    pop      = 1'b0;
    busy_d   = busy_q;
    idx_d    = idx_q;
    if (busy_q) begin
      dd_d = shifted[3:0];
      if (idx_q == last_idx) begin
        pop    = 1'b1;
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else begin
      dd_d   = trig_code;
      busy_d = start;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pst_q  <= 4'd0;
      dd_q   <= 4'd0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      pst_q  <= pst_d;
      dd_q   <= dd_d;
    end
  end

  assign busy      = busy_q;
  assign pst_out   = pst_q;
  assign ddata_out = dd_q;
endmodule

// File: rtl/trace_port.sv
module trace_port
  import trace_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    tgt_cfg,
  input  logic [1:0]    opd_cfg,
  input  logic [3:0]    core_pst,
  input  logic          branch_req,
  input  logic [TW-1:0] branch_addr,
  input  logic          opd_req,
  input  logic          opd_wr,
  input  logic [1:0]    opd_size,
  input  logic [TW-1:0] opd_data,
  input  logic          wdd_req,
  input  logic [1:0]    wdd_size,
  input  logic [TW-1:0] wdd_data,
  input  logic [3:0]    trig_code,
  output logic [3:0]    pst_out,
  output logic [3:0]    ddata_out,
  output logic          core_stall
);
  logic        push, pop, head_vld, full, ser_busy;
  trace_item_t new_item, head;

  trace_capture u_cap (
    .accept_en(!full), .tgt_cfg(tgt_cfg), .opd_cfg(opd_cfg),
    .branch_req(branch_req), .branch_addr(branch_addr),
    .opd_req(opd_req), .opd_wr(opd_wr), .opd_size(opd_size), .opd_data(opd_data),
    .wdd_req(wdd_req), .wdd_size(wdd_size), .wdd_data(wdd_data),
    .push(push), .item(new_item)
  );

  trace_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(new_item), .pop(pop),
    .head_vld(head_vld), .head(head), .full(full)
  );

  trace_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .core_pst(core_pst), .trig_code(trig_code),
    .head_vld(head_vld), .head(head), .pop(pop), .busy(ser_busy),
    .pst_out(pst_out), .ddata_out(ddata_out)
  );

  assign core_stall = full;
endmodule

// File: rtl/trace_port_chk.sv
module trace_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] core_pst,
  input logic       branch_req,
  input logic       opd_req,
  input logic       wdd_req,
  input logic [3:0] trig_code,
  input logic [3:0] pst_out,
  input logic [3:0] ddata_out,
  input logic       core_stall,
  input logic       ser_busy
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_MARK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pst_out[3:2] == 2'b10) |-> ($past(core_pst) == 4'd0)); // R6

  AST_PST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(core_pst) != 4'd0) |-> (pst_out == $past(core_pst))); // R2

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(core_stall)) |-> $past(branch_req || opd_req || wdd_req)); // R8

  AST_IDLE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(ser_busy)) |-> (ddata_out == $past(trig_code))); // R9
endmodule

bind trace_port trace_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_pst(core_pst), .branch_req(branch_req),
  .opd_req(opd_req), .wdd_req(wdd_req), .trig_code(trig_code),
  .pst_out(pst_out), .ddata_out(ddata_out), .core_stall(core_stall),
  .ser_busy(ser_busy)
);

// File: tb/sim_trace_port.sv
module sim_trace_port;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [1:0]  tgt_cfg, opd_cfg, opd_size, wdd_size;
  logic [3:0]  core_pst, trig_code;
  logic        branch_req, opd_req, opd_wr, wdd_req;
  logic [31:0] branch_addr, opd_data, wdd_data;
  logic [3:0]  pst_out, ddata_out;
  logic        core_stall;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int          got_n;
  int          got_bytes [4];
  logic [31:0] got_val [4];

  // {kind, tgt_cfg, opd_cfg, size, exp_bytes, data}; kind 0 branch, 1 read, 2 write, 3 wdd
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    52'h0_1_0_0_2_A5C37E19,
    52'h0_2_0_0_3_1234_5678,
    52'h0_3_0_0_4_9ABCDEF1,
    52'h0_0_0_0_0_DEAD_BEEF,
    52'h1_0_2_2_4_CAFE_F00D,
    52'h1_0_1_2_0_1111_2222,
    52'h2_0_1_0_1_0000_00A7,
    52'h2_0_2_1_0_3333_4444,
    52'h2_0_3_1_2_5555_6B9C,
    52'h3_0_0_1_2_7777_D2E3,
    52'h3_0_0_2_4_8F1E_2D3C,
    52'h1_0_3_3_4_4B5A_6978
  };

  trace_port u0 (
    .clk(clk), .rst_n(rst_n), .tgt_cfg(tgt_cfg), .opd_cfg(opd_cfg),
    .core_pst(core_pst), .branch_req(branch_req), .branch_addr(branch_addr),
    .opd_req(opd_req), .opd_wr(opd_wr), .opd_size(opd_size), .opd_data(opd_data),
    .wdd_req(wdd_req), .wdd_size(wdd_size), .wdd_data(wdd_data),
    .trig_code(trig_code), .pst_out(pst_out), .ddata_out(ddata_out),
    .core_stall(core_stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    branch_req = 0; opd_req = 0; wdd_req = 0; opd_wr = 0;
  endtask

  task automatic collect(input int cycles);
    int rem = 0;
    int pos = 0;
    int k;
    got_n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      k = (got_n > 0) ? ((got_n - 1 < 4) ? got_n - 1 : 3) : 0;
      if (rem > 0) begin
        got_val[k] = got_val[k] | ({28'd0, ddata_out} << (4 * pos));
        pos++;
        rem--;
      end else if (pst_out[3:2] == 2'b10) begin
        k = (got_n < 4) ? got_n : 3;
        got_bytes[k] = int'(pst_out[1:0]) + 1;
        got_val[k]   = 32'd0;
        rem = 2 * got_bytes[k];
        pos = 0;
        got_n++;
      end
    end
  endtask

  function automatic logic [31:0] mask_bytes(input logic [31:0] v, input int b);
    return (b >= 4) ? v : (v & ((32'd1 << (8 * b)) - 1));
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tgt_cfg = 0; opd_cfg = 0; core_pst = 0; trig_code = 0;
    branch_addr = 0; opd_data = 0; wdd_data = 0; opd_size = 0; wdd_size = 0;
    clear_req();
    repeat (3) @(negedge clk);
    chk(pst_out == 0 && ddata_out == 0 && core_stall == 0, "R1 reset",
        {23'd0, core_stall, ddata_out, pst_out}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  kind, tg, od, sz, eb;
      logic [31:0] dv;
      {kind, tg, od, sz, eb, dv} = VEC[i];
      tgt_cfg = tg[1:0]; opd_cfg = od[1:0];
      case (kind)
        4'd0: begin branch_req = 1; branch_addr = dv; core_pst = 4'h5; end
        4'd1: begin opd_req = 1; opd_wr = 0; opd_size = sz[1:0]; opd_data = dv; core_pst = 4'h1; end
        4'd2: begin opd_req = 1; opd_wr = 1; opd_size = sz[1:0]; opd_data = dv; core_pst = 4'h1; end
        default: begin wdd_req = 1; wdd_size = sz[1:0]; wdd_data = dv; core_pst = 4'h1; end
      endcase
      @(negedge clk);
      clear_req();
      chk(pst_out == ((kind == 0) ? 4'h5 : 4'h1), "R2 status passthrough", {28'd0, pst_out},
          (kind == 0) ? 32'h5 : 32'h1);
      core_pst = 0;
      collect(14);
      chk(got_n == ((eb == 0) ? 0 : 1), "R3/R4/R5 capture count", got_n, (eb == 0) ? 0 : 1);
      if (eb != 0 && got_n == 1) begin
        chk(got_bytes[0] == int'(eb), "R6 marker size", got_bytes[0], {28'd0, eb});
        chk(got_val[0] == mask_bytes(dv, int'(eb)), "R7 nibble value", got_val[0],
            mask_bytes(dv, int'(eb)));
      end
    end

    // R10: simultaneous requests, branch wins
    tgt_cfg = 2'b11; opd_cfg = 2'b11;
    branch_req = 1; branch_addr = 32'h0BAD_F00D;
    opd_req = 1; opd_wr = 1; opd_size = 2'b10; opd_data = 32'h1357_9BDF;
    wdd_req = 1; wdd_size = 2'b10; wdd_data = 32'h2468_ACE0;
    core_pst = 4'h5;
    @(negedge clk);
    clear_req(); core_pst = 0;
    collect(14);
    chk(got_n == 1, "R10 single capture", got_n, 1);
    chk(got_val[0] == 32'h0BAD_F00D, "R10 branch priority", got_val[0], 32'h0BAD_F00D);

    // R8 R11 R6: fill buffer while no marker slot exists
    tgt_cfg = 0; opd_cfg = 0; core_pst = 4'h1;
    wdd_req = 1; wdd_size = 2'b10; wdd_data = 32'hAAAA_0001;
    @(negedge clk);
    wdd_data = 32'hBBBB_0002;
    chk(core_stall == 0, "R8 one entry no stall", {31'd0, core_stall}, 0);
    @(negedge clk);
    chk(core_stall == 1, "R8 stall when full", {31'd0, core_stall}, 1);
    wdd_data = 32'hCCCC_0003;
    @(negedge clk);
    clear_req();
    chk(pst_out == 4'h1, "R6 no marker without slot", {28'd0, pst_out}, 32'h1);
    @(negedge clk);
    chk(pst_out == 4'h1 && core_stall == 1, "R6 still held", {27'd0, core_stall, pst_out}, 32'h11);
    core_pst = 0;
    collect(30);
    chk(got_n == 2, "R8 stalled request dropped", got_n, 2);
    chk(got_val[0] == 32'hAAAA_0001, "R11 order first", got_val[0], 32'hAAAA_0001);
    chk(got_val[1] == 32'hBBBB_0002, "R11 order second", got_val[1], 32'hBBBB_0002);
    chk(core_stall == 0, "R8 stall released", {31'd0, core_stall}, 0);

    // R9: trigger code on idle data bus
    trig_code = 4'h6;
    @(negedge clk);
    trig_code = 0;
    chk(ddata_out == 4'h6, "R9 trigger shown", {28'd0, ddata_out}, 32'h6);
    @(negedge clk);
    chk(ddata_out == 4'h0, "R9 idle zero", {28'd0, ddata_out}, 32'h0);

    // R9: trigger during serialisation does not disturb nibbles
    wdd_req = 1; wdd_size = 2'b10; wdd_data = 32'h7654_3210; core_pst = 4'h1;
    @(negedge clk);
    clear_req(); core_pst = 0; trig_code = 4'hF;
    collect(14);
    trig_code = 0;
    chk(got_n >= 1 && got_val[0] == 32'h7654_3210, "R9 data over trigger", got_val[0], 32'h7654_3210);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule